// File: doc/BRIEF.md
# Separate-Port Two-Beat Burst SRAM Cycle Model

This block is a synthesizable device-side model of a double-data-rate static memory. It has one port for write data and a separate port for read data, and every access moves exactly two words. Real double-edge clocking is avoided. The model runs on one internal clock at twice the command rate. An input flag marks each internal cycle as the rising half or the falling half of the command clock. One internal cycle is called a slot, and a pair of slots (rising half, then falling half) is one command period.

A command is accepted at the edge that ends a rising-half slot when the start strobe is low. The direction and the base address are captured together at that edge. A write takes its two data words one command period later, on two consecutive edges, and each word carries its own active-low lane-write mask. A read presents its two words one and a half command periods after the command, in two consecutive slots, with a tag that tells the first word from the second. The second word of a burst always lives at the base address with bit 0 inverted.

A completed write burst is held in a posted register and moves into the array only when the next write burst completes. Reads merge the posted words over the array contents lane by lane, so a read always returns the newest data.

Top module: `sio_burst_sram`

## Requirements
- R1: While `rst` is high, and afterwards until the first read beat, `rd_valid` and `rd_second` are 0 and `rd_data` is all zeros.
- R2: A command is accepted only at a rising `clk` edge where `half_fall` is 0 and `go_n` is 0. If `go_n` is low in a slot with `half_fall` = 1, no operation starts.
- R3: For a read accepted at edge E0, the word at the base address A is registered at edge E3 and is valid for the slot that follows E3.
- R4: A read burst has two beats in consecutive slots. The first beat has `rd_second` = 0 and holds word A. The second beat has `rd_second` = 1 and holds the word at A with bit 0 inverted, so the pair never leaves its two-word group.
- R5: For a write accepted at edge E0, `wr_data` is sampled at E2 as the word for A and at E3 as the word for A with bit 0 inverted. `wr_data` and `wr_lane_n` are ignored at every other edge.
- R6: Lane l is data bits [9l+8:9l]. When bit l of `wr_lane_n` is 0 during a write beat, lane l of that beat's word is written. When the bit is 1, that lane keeps its previous value. The mask is sampled separately for each beat.
- R7: A command, read or write in any order, can be accepted in every command period with no idle period between bursts.
- R8: A read returns, for each lane, the value of the last write to that lane that was accepted before the read. This holds even when that write is still in the posted register.
- R9: With `go_n` high no new operation starts, but a burst already accepted still delivers or takes both of its beats.
- R10: `rd_data` is all zeros in every slot where `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the command rate |
| rst | input | 1 | Synchronous active-high reset |
| half_fall | input | 1 | 0 = rising half of the command clock, 1 = falling half |
| go_n | input | 1 | Active-low command start strobe |
| dir_rd | input | 1 | 1 = read, 0 = write, captured with the command |
| cmd_addr | input | 6 | Burst base address |
| wr_data | input | 18 | Write data word, two 9-bit lanes |
| wr_lane_n | input | 2 | Active-low per-lane write enables for the current beat |
| rd_valid | output | 1 | Read beat present |
| rd_second | output | 1 | 0 = first word of the burst, 1 = second word |
| rd_data | output | 18 | Read data word |

## Verification
A wrong entry in the command stage register shows up as a read beat in the wrong slot, or a missing one. It appears four or five slots after the command that was disturbed. A fault in the posted-write path or in the lane merge does not show right away. It appears only when a later read targets the affected word, which can be many commands later. For that reason the stimulus reads back freshly written addresses in the very next command period, and it also reads them after further writes have pushed the posted burst into the array. Writes with partial masks and writes with all lanes disabled make a lane-enable fault visible in the data of the next read of that word.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int unsigned AW     = 6;
    localparam int unsigned LANES  = 2;
    localparam int unsigned LANE_W = 9;
    localparam int unsigned DW     = LANES * LANE_W;
    localparam int unsigned DEPTH  = 1 << AW;

    typedef enum logic {
        OP_WR = 1'b0,
        OP_RD = 1'b1
    } op_e;

    typedef struct packed {
        logic          vld;
        op_e           op;
        logic [AW-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic             vld;
        logic [AW-1:0]    base;
        logic [DW-1:0]    d0;
        logic [DW-1:0]    d1;
        logic [LANES-1:0] en0;
        logic [LANES-1:0] en1;
    } post_t;

    function automatic logic [AW-1:0] partner(input logic [AW-1:0] a);
        return {a[AW-1:1], ~a[0]};
    endfunction

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [LANES-1:0] en);
        logic [DW-1:0] r;
        r = old_w;
        for (int l = 0; l < LANES; l++)
            if (en[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
        return r;
    endfunction

endpackage

// File: rtl/sio_cmd_pipe.sv
module sio_cmd_pipe
    import sio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          half_fall,
    input  logic          go_n,
    input  logic          dir_rd,
    input  logic [AW-1:0] cmd_addr,
    output cmd_t          st2,
    output cmd_t          st3,
    output cmd_t          st4
);

    cmd_t st1;
    cmd_t take;

    always_comb begin
        take = '0;
        if (!half_fall && !go_n) begin
            take.vld  = 1'b1;
            take.op   = op_e'(dir_rd);
            take.addr = cmd_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st1 <= '0;
            st2 <= '0;
            st3 <= '0;
            st4 <= '0;
        end else begin
            st1 <= take;
            st2 <= st1;
            st3 <= st2;
            st4 <= st3;
        end
    end

endmodule

// File: rtl/sio_wr_post.sv
module sio_wr_post
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             st2,
    input  cmd_t             st3,
    input  logic [DW-1:0]    wr_data,
    input  logic [LANES-1:0] wr_lane_n,
    input  logic [AW-1:0]    look_addr,
    input  logic [DW-1:0]    look_arr,
    output logic [DW-1:0]    look_word,
    output logic             cm_go,
    output post_t            cm
);

    logic             beat0_take;
    logic             beat1_take;
    logic [DW-1:0]    hold_d;
    logic [LANES-1:0] hold_en;
    post_t            pend;

    assign beat0_take = st2.vld && (st2.op == OP_WR);
    assign beat1_take = st3.vld && (st3.op == OP_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_d  <= '0;
            hold_en <= '0;
            pend    <= '0;
        end else begin
            if (beat0_take) begin
                hold_d  <= wr_data;
                hold_en <= ~wr_lane_n;
            end
            if (beat1_take) begin
                pend.vld  <= 1'b1;
                pend.base <= st3.addr;
                pend.d0   <= hold_d;
                pend.en0  <= hold_en;
                pend.d1   <= wr_data;
                pend.en1  <= ~wr_lane_n;
            end
        end
    end

    // retire the posted burst when the next one completes
    assign cm_go = beat1_take && pend.vld;
    assign cm    = pend;

    always_comb begin
        look_word = look_arr;
        if (pend.vld && look_addr == pend.base)
            look_word = lane_merge(look_word, pend.d0, pend.en0);
        if (pend.vld && look_addr == partner(pend.base))
            look_word = lane_merge(look_word, pend.d1, pend.en1);
    end

endmodule

// File: rtl/sio_store.sv
module sio_store
    import sio_pkg::*;
(
    input  logic          clk,
    input  logic          cm_go,
    input  post_t         cm,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (cm_go) begin
            mem[cm.base]          <= lane_merge(mem[cm.base], cm.d0, cm.en0);
            mem[partner(cm.base)] <= lane_merge(mem[partner(cm.base)], cm.d1, cm.en1);
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sio_rd_out.sv
module sio_rd_out
    import sio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          st3,
    input  cmd_t          st4,
    input  logic [DW-1:0] look_word,
    output logic [AW-1:0] look_addr,
    output logic          rd_valid,
    output logic          rd_second,
    output logic [DW-1:0] rd_data
);

    logic first_go;
    logic second_go;

    assign first_go  = st3.vld && (st3.op == OP_RD);
    assign second_go = st4.vld && (st4.op == OP_RD);
    assign look_addr = first_go ? st3.addr : partner(st4.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_second <= 1'b0;
            rd_data   <= '0;
        end else if (first_go) begin
            rd_valid  <= 1'b1;
            rd_second <= 1'b0;
            rd_data   <= look_word;
        end else if (second_go) begin
            rd_valid  <= 1'b1;
            rd_second <= 1'b1;
            rd_data   <= look_word;
        end else begin
            rd_valid  <= 1'b0;
            rd_second <= 1'b0;
            rd_data   <= '0;
        end
    end

endmodule

// File: rtl/sio_burst_sram.sv
module sio_burst_sram
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             half_fall,
    input  logic             go_n,
    input  logic             dir_rd,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [LANES-1:0] wr_lane_n,
    output logic             rd_valid,
    output logic             rd_second,
    output logic [DW-1:0]    rd_data
);

    cmd_t          st2, st3, st4;
    logic [AW-1:0] look_addr;
    logic [DW-1:0] look_arr;
    logic [DW-1:0] look_word;
    logic          cm_go;
    post_t         cm;

    sio_cmd_pipe u_cmd (
        .clk       (clk),
        .rst       (rst),
        .half_fall (half_fall),
        .go_n      (go_n),
        .dir_rd    (dir_rd),
        .cmd_addr  (cmd_addr),
        .st2       (st2),
        .st3       (st3),
        .st4       (st4)
    );

    sio_wr_post u_post (
        .clk       (clk),
        .rst       (rst),
        .st2       (st2),
        .st3       (st3),
        .wr_data   (wr_data),
        .wr_lane_n (wr_lane_n),
        .look_addr (look_addr),
        .look_arr  (look_arr),
        .look_word (look_word),
        .cm_go     (cm_go),
        .cm        (cm)
    );

    sio_store u_store (
        .clk   (clk),
        .cm_go (cm_go),
        .cm    (cm),
        .raddr (look_addr),
        .rdata (look_arr)
    );

    sio_rd_out u_rd (
        .clk       (clk),
        .rst       (rst),
        .st3       (st3),
        .st4       (st4),
        .look_word (look_word),
        .look_addr (look_addr),
        .rd_valid  (rd_valid),
        .rd_second (rd_second),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/sio_sram_chk.sv
module sio_sram_chk
    import sio_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          half_fall,
    input logic          go_n,
    input logic          dir_rd,
    input logic          rd_valid,
    input logic          rd_second,
    input logic [DW-1:0] rd_data
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!rd_valid && !rd_second));

    assert_no_spurious_start_R2: assert property (@(posedge clk) disable iff (rst)
        (half_fall || go_n || !dir_rd) |-> ##4 !(rd_valid && !rd_second));

    assert_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (!half_fall && !go_n && dir_rd) |-> ##4 (rd_valid && !rd_second));

    assert_second_beat_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_second) |=> (rd_valid && rd_second));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));

endmodule

bind sio_burst_sram sio_sram_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .half_fall (half_fall),
    .go_n      (go_n),
    .dir_rd    (dir_rd),
    .rd_valid  (rd_valid),
    .rd_second (rd_second),
    .rd_data   (rd_data)
);

// File: tb/sim_sio_burst_sram.sv
module sim_sio_burst_sram;
    import sio_pkg::*;

    localparam int NSLOT = 4000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst, half_fall, go_n, dir_rd;
    logic [AW-1:0]    cmd_addr;
    logic [DW-1:0]    wr_data;
    logic [LANES-1:0] wr_lane_n;
    logic             rd_valid, rd_second;
    logic [DW-1:0]    rd_data;

    sio_burst_sram u0 (
        .clk(clk), .rst(rst), .half_fall(half_fall), .go_n(go_n), .dir_rd(dir_rd),
        .cmd_addr(cmd_addr), .wr_data(wr_data), .wr_lane_n(wr_lane_n),
        .rd_valid(rd_valid), .rd_second(rd_second), .rd_data(rd_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [DW-1:0]    ref_mem [DEPTH];
    logic             ev [8];
    logic             eb [8];
    logic [DW-1:0]    ed [8];
    logic             wv [8];
    logic [DW-1:0]    wd [8];
    logic [LANES-1:0] wm [8];
    logic [AW-1:0]    last_wr;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // lane l = bits [9l+8:9l]; mask bit low means write that lane
    function automatic logic [DW-1:0] apply_lanes(input logic [DW-1:0] old_w,
                                                  input logic [DW-1:0] new_w,
                                                  input logic [LANES-1:0] m_n);
        logic [DW-1:0] r;
        r = old_w;
        for (int l = 0; l < LANES; l++)
            if (!m_n[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
        return r;
    endfunction

    function automatic logic [AW-1:0] pair_of(input logic [AW-1:0] a);
        return a ^ AW'(1);
    endfunction

    // R5: beats land two and three slots after the command slot
    task automatic issue_wr(input int n, input logic [AW-1:0] a,
                            input logic [LANES-1:0] m0, input logic [LANES-1:0] m1);
        logic [DW-1:0] d0, d1;
        d0 = DW'($urandom);
        d1 = DW'($urandom);
        go_n = 1'b0; dir_rd = 1'b0; cmd_addr = a;
        ref_mem[a]          = apply_lanes(ref_mem[a], d0, m0);
        ref_mem[pair_of(a)] = apply_lanes(ref_mem[pair_of(a)], d1, m1);
        wv[(n+2)%8] = 1'b1; wd[(n+2)%8] = d0; wm[(n+2)%8] = m0;
        wv[(n+3)%8] = 1'b1; wd[(n+3)%8] = d1; wm[(n+3)%8] = m1;
        last_wr = a;
    endtask

    // R3/R4: first word visible four slots after the command slot, second word next
    task automatic issue_rd(input int n, input logic [AW-1:0] a);
        go_n = 1'b0; dir_rd = 1'b1; cmd_addr = a;
        ev[(n+4)%8] = 1'b1; eb[(n+4)%8] = 1'b0; ed[(n+4)%8] = ref_mem[a];
        ev[(n+5)%8] = 1'b1; eb[(n+5)%8] = 1'b1; ed[(n+5)%8] = ref_mem[pair_of(a)];
    endtask

    initial begin
        int r;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 8; i++) begin
            ev[i] = 0; eb[i] = 0; ed[i] = '0; wv[i] = 0; wd[i] = '0; wm[i] = '1;
        end
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        last_wr = '0;
        rst = 1'b1; half_fall = 1'b0; go_n = 1'b0; dir_rd = 1'b1;
        cmd_addr = '0; wr_data = '0; wr_lane_n = '0;
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset even with a read strobe present
        chk(rd_valid === 1'b0, "R1", "rd_valid in reset", DW'(rd_valid), '0);
        chk(rd_second === 1'b0, "R1", "rd_second in reset", DW'(rd_second), '0);
        chk(rd_data === '0, "R1", "rd_data in reset", rd_data, '0);
        rst = 1'b0; go_n = 1'b1;
        for (int n = 0; n < NSLOT; n++) begin
            int s;
            if (n > 0) @(negedge clk);
            s = n % 8;
            // R2/R3/R9: a beat appears exactly where a read command predicts it
            chk(rd_valid === ev[s], "R2/R3/R9", "rd_valid", DW'(rd_valid), DW'(ev[s]));
            if (ev[s]) begin
                chk(rd_second === eb[s], "R4", "rd_second", DW'(rd_second), DW'(eb[s]));
                // R6/R8: newest data per lane, posted or retired
                chk(rd_data === ed[s], "R6/R8", "rd_data", rd_data, ed[s]);
            end else begin
                chk(rd_data === '0, "R10", "rd_data idle", rd_data, '0);
            end
            ev[s] = 1'b0;
            if (wv[s]) begin
                wr_data = wd[s]; wr_lane_n = wm[s]; wv[s] = 1'b0;
            end else begin
                // R5: data outside beat slots must be ignored
                wr_data = DW'($urandom); wr_lane_n = LANES'($urandom);
            end
            half_fall = n[0];
            if (n[0]) begin
                // R2: strobe in falling half is noise
                go_n = 1'($urandom); dir_rd = 1'($urandom); cmd_addr = AW'($urandom);
            end else if (n >= NSLOT - 8) begin
                go_n = 1'b1; dir_rd = 1'($urandom); cmd_addr = AW'($urandom);
            end else if (n < 64) begin
                issue_wr(n, AW'(n), '0, '0);
            end else if (n < 192) begin
                // R7: back-to-back reads, odd bases check the pair wrap (R4)
                issue_rd(n, AW'((n - 64) / 2));
            end else begin
                r = int'($urandom % 8);
                if (r < 2) begin
                    go_n = 1'b1; dir_rd = 1'($urandom); cmd_addr = AW'($urandom); // R9
                end else if (r < 5) begin
                    issue_wr(n, AW'($urandom), LANES'($urandom), LANES'($urandom));
                end else if (r < 7) begin
                    issue_rd(n, AW'($urandom));
                end else begin
                    issue_rd(n, ($urandom % 2) ? last_wr : pair_of(last_wr)); // R8
                end
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule